// File: doc/BRIEF.md
# Processor Status to S100 Command Decoder

This block sits between a 16-bit processor and an S100 backplane. The processor marks every cycle with a 4-bit status code, a read/write line, a byte/word line and an active-low data strobe. The block turns these inputs into the S100 status lines (input, output, memory read, memory write, opcode fetch, interrupt acknowledge, 16-bit transfer request) and the two bus control strobes (write strobe and data-in enable). The whole path is combinational, so the outputs follow the processor's signals with gate delay only.

During an interrupt-acknowledge cycle the block also handles the data and address paths. It forces the upper data byte returned to the processor to all ones. While data-in is active, it places the 8-bit interrupt vector on the low address lines and drives the upper address lines to a fixed level. Hold request and bus acknowledge pass straight through. A parameter sets the memory-write status to one of two timings: valid for the whole cycle, or only while the data strobe is active.

Top module: `s100_cmd_decoder`

## Requirements
- R1: Status code 0010 is an I/O cycle. It raises `s_out` when `rd_wr_n` is 0 and `s_inp` when `rd_wr_n` is 1. All other codes leave both low.
- R2: `s_memr` is high exactly when the code is 1000, 1001, 1100 or 1101 and `rd_wr_n` is 1. The data strobe has no effect on it.
- R3: With `MWRT_STROBED`=0, `s_mwrt` is high exactly when the code is one of the R2 memory codes and `rd_wr_n` is 0, whatever `ds_n` is.
- R4: With `MWRT_STROBED`=1, `s_mwrt` also requires `ds_n`=0.
- R5: `s_m1` is high exactly for code 1101, whatever the read/write line and the data strobe are.
- R6: `wr_n` is 0 exactly when `ds_n`=0 and `rd_wr_n`=0. `dbin` is 1 exactly when `ds_n`=0 and `rd_wr_n`=1.
- R7: `xfer16_n` equals `cpu_byte_nword` (0 = word, which requests a 16-bit transfer). `busrq_n` equals `hold_req_n`. `hold_ack` is the inverse of `busack_n`.
- R8: With the default parameters, `s_inta` is high for codes 0111 (vectored) and 0101 (non-maskable) and low for 0110 (non-vectored) and every other code.
- R9: While `s_inta` is high, `cpu_data[15:8]` is FF hex and `cpu_data[7:0]` equals `bus_data[7:0]`. Otherwise `cpu_data` equals `bus_data`.
- R10: While `s_inta` and `dbin` are both high, `bus_addr` is {8'h00, `vec_in`}. Otherwise `bus_addr` equals `cpu_addr`.
- R11: Codes 0000, 0001, 0011, 0100, 1010, 1011, 1110 and 1111 raise none of the six status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_code | input | 4 | Processor cycle status code |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| cpu_byte_nword | input | 1 | 1 = byte transfer, 0 = word transfer |
| ds_n | input | 1 | Processor data strobe, active low |
| hold_req_n | input | 1 | Bus hold request from the backplane, active low |
| busack_n | input | 1 | Processor bus acknowledge, active low |
| vec_in | input | 8 | Interrupt vector lines from the backplane |
| cpu_addr | input | 16 | Processor address |
| bus_data | input | 16 | Data from the backplane toward the processor |
| s_out | output | 1 | Output-cycle status |
| s_inp | output | 1 | Input-cycle status |
| s_memr | output | 1 | Memory-read status |
| s_mwrt | output | 1 | Memory-write status |
| s_m1 | output | 1 | Opcode-fetch status |
| s_inta | output | 1 | Interrupt-acknowledge status |
| xfer16_n | output | 1 | 16-bit transfer request, active low |
| wr_n | output | 1 | Write strobe, active low |
| dbin | output | 1 | Data-in enable |
| busrq_n | output | 1 | Bus request to the processor, active low |
| hold_ack | output | 1 | Hold acknowledge to the backplane |
| bus_addr | output | 16 | Address driven onto the backplane |
| cpu_data | output | 16 | Data returned to the processor |

## Verification
The bench tries all 16 status codes against both read/write levels and both data-strobe levels. This separates I/O from memory from acknowledge codes, and it shows which outputs depend on the strobe: memory-read and fetch must ignore it, the control strobes and the strobed memory write must follow it. Two instances with the whole-cycle and strobed memory-write settings run side by side on the same stimulus, so the only difference expected between them is in `s_mwrt`. The vector, address, data and byte/word inputs change from step to step, so the substitution paths show whether each bit comes from the pass-through or from the forced value.

// File: rtl/s100_cmd_pkg.sv
package s100_cmd_pkg;

  localparam logic [3:0] ST_IO      = 4'b0010;
  localparam logic [3:0] ST_NMI_ACK = 4'b0101;
  localparam logic [3:0] ST_NVI_ACK = 4'b0110;
  localparam logic [3:0] ST_VI_ACK  = 4'b0111;
  localparam logic [3:0] ST_DATA    = 4'b1000;
  localparam logic [3:0] ST_STACK   = 4'b1001;
  localparam logic [3:0] ST_PROG    = 4'b1100;
  localparam logic [3:0] ST_FETCH   = 4'b1101;

  typedef struct packed {
    logic io;
    logic mem;
    logic fetch;
    logic ack;
  } cyc_class_t;

  typedef struct packed {
    logic s_out;
    logic s_inp;
    logic s_memr;
    logic s_mwrt;
    logic s_m1;
    logic s_inta;
  } bus_status_t;

endpackage

// File: rtl/s100_cycle_classify.sv
module s100_cycle_classify
  import s100_cmd_pkg::*;
#(
  parameter bit ACK_VI  = 1'b1,
  parameter bit ACK_NMI = 1'b1,
  parameter bit ACK_NVI = 1'b0
) (
  input  logic [3:0]  st_code,
  output cyc_class_t  cls
);

  always_comb begin
    cls = '0;
    unique case (st_code)
      ST_IO:      cls.io    = 1'b1;
      ST_DATA,
      ST_STACK,
      ST_PROG:    cls.mem   = 1'b1;
      ST_FETCH: begin
        cls.mem   = 1'b1;
        cls.fetch = 1'b1;
      end
      ST_VI_ACK:  cls.ack   = ACK_VI;
      ST_NMI_ACK: cls.ack   = ACK_NMI;
      ST_NVI_ACK: cls.ack   = ACK_NVI;
      default:    cls       = '0;
    endcase
  end

endmodule

// File: rtl/s100_strobe_gen.sv
module s100_strobe_gen
  import s100_cmd_pkg::*;
#(
  parameter bit MWRT_STROBED = 1'b0
) (
  input  cyc_class_t  cls,
  input  logic        rd_wr_n,
  input  logic        ds_n,
  output bus_status_t stat,
  output logic        wr_n,
  output logic        dbin
);

  logic ds_act;
  logic mwrt_q;

  assign ds_act = ~ds_n;

  generate
    if (MWRT_STROBED) begin : g_mwrt_strobed
      assign mwrt_q = cls.mem & ~rd_wr_n & ds_act;
    end else begin : g_mwrt_cycle
      assign mwrt_q = cls.mem & ~rd_wr_n;
    end
  endgenerate

  always_comb begin
    stat.s_out  = cls.io & ~rd_wr_n;
    stat.s_inp  = cls.io & rd_wr_n;
    stat.s_memr = cls.mem & rd_wr_n;
    stat.s_mwrt = mwrt_q;
    stat.s_m1   = cls.fetch;
    stat.s_inta = cls.ack;
    wr_n        = ~(ds_act & ~rd_wr_n);
    dbin        = ds_act & rd_wr_n;
  end

endmodule

// File: rtl/s100_ack_path.sv
module s100_ack_path #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int VEC_W     = 8,
  parameter bit ADDR_FILL = 1'b0
) (
  input  logic              inta,
  input  logic              dbin,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] cpu_data
);

  localparam int UP_W  = DATA_W - VEC_W;
  localparam int AHI_W = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] vec_addr;
  logic              vec_sel;

  assign vec_addr = {{AHI_W{ADDR_FILL}}, vec_in};
  assign vec_sel  = inta & dbin;

  always_comb begin
    bus_addr = vec_sel ? vec_addr : cpu_addr;
    cpu_data = bus_data;
    if (inta) cpu_data[DATA_W-1 -: UP_W] = {UP_W{1'b1}};
  end

endmodule

// File: rtl/s100_cmd_decoder.sv
module s100_cmd_decoder
  import s100_cmd_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int VEC_W        = 8,
  parameter bit MWRT_STROBED = 1'b0,
  parameter bit ACK_VI       = 1'b1,
  parameter bit ACK_NMI      = 1'b1,
  parameter bit ACK_NVI      = 1'b0,
  parameter bit ADDR_FILL    = 1'b0
) (
  input  logic [3:0]        st_code,
  input  logic              rd_wr_n,
  input  logic              cpu_byte_nword,
  input  logic              ds_n,
  input  logic              hold_req_n,
  input  logic              busack_n,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              s_out,
  output logic              s_inp,
  output logic              s_memr,
  output logic              s_mwrt,
  output logic              s_m1,
  output logic              s_inta,
  output logic              xfer16_n,
  output logic              wr_n,
  output logic              dbin,
  output logic              busrq_n,
  output logic              hold_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] cpu_data
);

  cyc_class_t  cls;
  bus_status_t stat;

  s100_cycle_classify #(
    .ACK_VI (ACK_VI),
    .ACK_NMI(ACK_NMI),
    .ACK_NVI(ACK_NVI)
  ) u_classify (
    .st_code(st_code),
    .cls    (cls)
  );

  s100_strobe_gen #(
    .MWRT_STROBED(MWRT_STROBED)
  ) u_strobe (
    .cls    (cls),
    .rd_wr_n(rd_wr_n),
    .ds_n   (ds_n),
    .stat   (stat),
    .wr_n   (wr_n),
    .dbin   (dbin)
  );

  s100_ack_path #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .ADDR_FILL(ADDR_FILL)
  ) u_ack (
    .inta    (stat.s_inta),
    .dbin    (dbin),
    .vec_in  (vec_in),
    .cpu_addr(cpu_addr),
    .bus_data(bus_data),
    .bus_addr(bus_addr),
    .cpu_data(cpu_data)
  );

  assign s_out    = stat.s_out;
  assign s_inp    = stat.s_inp;
  assign s_memr   = stat.s_memr;
  assign s_mwrt   = stat.s_mwrt;
  assign s_m1     = stat.s_m1;
  assign s_inta   = stat.s_inta;
  assign xfer16_n = cpu_byte_nword;
  assign busrq_n  = hold_req_n;
  assign hold_ack = ~busack_n;

endmodule

// File: rtl/s100_cmd_decoder_chk.sv
module s100_cmd_decoder_chk #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int VEC_W        = 8,
  parameter bit MWRT_STROBED = 1'b0
) (
  input logic [3:0]        st_code,
  input logic              rd_wr_n,
  input logic              ds_n,
  input logic [VEC_W-1:0]  vec_in,
  input logic [DATA_W-1:0] bus_data,
  input logic              s_out,
  input logic              s_inp,
  input logic              s_memr,
  input logic              s_mwrt,
  input logic              s_m1,
  input logic              s_inta,
  input logic              wr_n,
  input logic              dbin,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] cpu_data
);

  localparam int UP_W = DATA_W - VEC_W;

  always_comb begin
    p_io_excl_r1: assert (!(s_out && s_inp));
    p_io_code_r1: assert (!(s_out || s_inp) || st_code == 4'b0010);
    p_mem_excl_r2: assert (!(s_memr && s_mwrt));
    p_memr_dir_r2: assert (!s_memr || rd_wr_n);
    p_mwrt_dir_r3: assert (!s_mwrt || !rd_wr_n);
    p_mwrt_strb_r4: assert (!(MWRT_STROBED && s_mwrt) || !ds_n);
    p_fetch_is_mem_r5: assert (!(s_m1 && rd_wr_n) || s_memr);
    p_strobe_excl_r6: assert (!(!wr_n && dbin));
    p_strobe_ds_r6: assert (ds_n ? (wr_n && !dbin) : 1'b1);
    p_inta_vs_mem_r8: assert (!(s_inta && (s_memr || s_mwrt || s_out || s_inp)));
    p_upper_fill_r9: assert (!s_inta || cpu_data[DATA_W-1 -: UP_W] == {UP_W{1'b1}});
    p_lower_pass_r9: assert (cpu_data[VEC_W-1:0] == bus_data[VEC_W-1:0]);
    p_vec_addr_r10: assert (!(s_inta && dbin) || bus_addr[VEC_W-1:0] == vec_in);
  end

endmodule

bind s100_cmd_decoder s100_cmd_decoder_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .VEC_W       (VEC_W),
  .MWRT_STROBED(MWRT_STROBED)
) u_chk (
  .st_code (st_code),
  .rd_wr_n (rd_wr_n),
  .ds_n    (ds_n),
  .vec_in  (vec_in),
  .bus_data(bus_data),
  .s_out   (s_out),
  .s_inp   (s_inp),
  .s_memr  (s_memr),
  .s_mwrt  (s_mwrt),
  .s_m1    (s_m1),
  .s_inta  (s_inta),
  .wr_n    (wr_n),
  .dbin    (dbin),
  .bus_addr(bus_addr),
  .cpu_data(cpu_data)
);

// File: tb/s100_cmd_decoder_test.sv
module s100_cmd_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic [3:0]  code;
    logic        out, inp, memr, mwrt_c, mwrt_s, m1, inta;
    logic        xfer16_n, wr_n, dbin, busrq_n, hold_ack;
    logic [15:0] addr, data;
  } exp_t;

  logic        clk;
  logic [3:0]  st_code;
  logic        rd_wr_n, cpu_byte_nword, ds_n, hold_req_n, busack_n;
  logic [7:0]  vec_in;
  logic [15:0] cpu_addr, bus_data;

  logic        s_out, s_inp, s_memr, s_mwrt, s_m1, s_inta;
  logic        xfer16_n, wr_n, dbin, busrq_n, hold_ack;
  logic [15:0] bus_addr, cpu_data;

  logic        b_out, b_inp, b_memr, b_mwrt, b_m1, b_inta;
  logic        b_xfer16_n, b_wr_n, b_dbin, b_busrq_n, b_hold_ack;
  logic [15:0] b_bus_addr, b_cpu_data;

  int   total = 0;
  int   bad   = 0;
  int   cycles = 0;
  bit   done  = 0;
  exp_t sb_q[$];

  s100_cmd_decoder #(.MWRT_STROBED(1'b0)) uut (
    .st_code(st_code), .rd_wr_n(rd_wr_n), .cpu_byte_nword(cpu_byte_nword),
    .ds_n(ds_n), .hold_req_n(hold_req_n), .busack_n(busack_n),
    .vec_in(vec_in), .cpu_addr(cpu_addr), .bus_data(bus_data),
    .s_out(s_out), .s_inp(s_inp), .s_memr(s_memr), .s_mwrt(s_mwrt),
    .s_m1(s_m1), .s_inta(s_inta), .xfer16_n(xfer16_n), .wr_n(wr_n),
    .dbin(dbin), .busrq_n(busrq_n), .hold_ack(hold_ack),
    .bus_addr(bus_addr), .cpu_data(cpu_data)
  );

  s100_cmd_decoder #(.MWRT_STROBED(1'b1)) uut_strb (
    .st_code(st_code), .rd_wr_n(rd_wr_n), .cpu_byte_nword(cpu_byte_nword),
    .ds_n(ds_n), .hold_req_n(hold_req_n), .busack_n(busack_n),
    .vec_in(vec_in), .cpu_addr(cpu_addr), .bus_data(bus_data),
    .s_out(b_out), .s_inp(b_inp), .s_memr(b_memr), .s_mwrt(b_mwrt),
    .s_m1(b_m1), .s_inta(b_inta), .xfer16_n(b_xfer16_n), .wr_n(b_wr_n),
    .dbin(b_dbin), .busrq_n(b_busrq_n), .hold_ack(b_hold_ack),
    .bus_addr(b_bus_addr), .cpu_data(b_cpu_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp, input logic [3:0] code);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s code=%b actual=%h expected=%h", req, code, act, exp);
    end
  endtask

  // Reference model built from the requirement list
  task automatic drive(input logic [3:0] c, input logic rw, input logic ds,
                       input logic bw, input logic hr, input logic ba,
                       input logic [7:0] v, input logic [15:0] a,
                       input logic [15:0] d);
    exp_t e;
    bit   is_mem;
    bit   ds_on;
    @(posedge clk);
    st_code = c; rd_wr_n = rw; ds_n = ds; cpu_byte_nword = bw;
    hold_req_n = hr; busack_n = ba; vec_in = v; cpu_addr = a; bus_data = d;
    is_mem     = (c == 4'h8) || (c == 4'h9) || (c == 4'hC) || (c == 4'hD);
    ds_on      = (ds == 1'b0);
    e.code     = c;
    e.out      = (c == 4'h2) && !rw;
    e.inp      = (c == 4'h2) && rw;
    e.memr     = is_mem && rw;
    e.mwrt_c   = is_mem && !rw;
    e.mwrt_s   = is_mem && !rw && ds_on;
    e.m1       = (c == 4'hD);
    e.inta     = (c == 4'h7) || (c == 4'h5);
    e.xfer16_n = bw;
    e.wr_n     = !(ds_on && !rw);
    e.dbin     = ds_on && rw;
    e.busrq_n  = hr;
    e.hold_ack = !ba;
    e.addr     = (e.inta && e.dbin) ? {8'h00, v} : a;
    e.data     = e.inta ? {8'hFF, d[7:0]} : d;
    sb_q.push_back(e);
  endtask

  // Monitor: samples on the falling edge, half a period after the drive
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      bit   is_rsv;
      e = sb_q.pop_front();
      check({s_out, s_inp} == {e.out, e.inp}, "R1", {14'd0, s_out, s_inp},
            {14'd0, e.out, e.inp}, e.code);
      check(s_memr == e.memr && b_memr == e.memr, "R2", {14'd0, s_memr, b_memr},
            {14'd0, e.memr, e.memr}, e.code);
      check(s_mwrt == e.mwrt_c, "R3", {15'd0, s_mwrt}, {15'd0, e.mwrt_c}, e.code);
      check(b_mwrt == e.mwrt_s, "R4", {15'd0, b_mwrt}, {15'd0, e.mwrt_s}, e.code);
      check(s_m1 == e.m1, "R5", {15'd0, s_m1}, {15'd0, e.m1}, e.code);
      check({wr_n, dbin, b_wr_n, b_dbin} == {e.wr_n, e.dbin, e.wr_n, e.dbin}, "R6",
            {12'd0, wr_n, dbin, b_wr_n, b_dbin}, {12'd0, e.wr_n, e.dbin, e.wr_n, e.dbin},
            e.code);
      check({xfer16_n, busrq_n, hold_ack} == {e.xfer16_n, e.busrq_n, e.hold_ack}, "R7",
            {13'd0, xfer16_n, busrq_n, hold_ack}, {13'd0, e.xfer16_n, e.busrq_n, e.hold_ack},
            e.code);
      check(s_inta == e.inta, "R8", {15'd0, s_inta}, {15'd0, e.inta}, e.code);
      check(cpu_data == e.data, "R9", cpu_data, e.data, e.code);
      check(bus_addr == e.addr, "R10", bus_addr, e.addr, e.code);
      is_rsv = !(e.code inside {4'h2, 4'h5, 4'h7, 4'h8, 4'h9, 4'hC, 4'hD});
      if (is_rsv)
        check({s_out, s_inp, s_memr, s_mwrt, s_m1, s_inta} == 6'd0, "R11",
              {10'd0, s_out, s_inp, s_memr, s_mwrt, s_m1, s_inta}, 16'd0, e.code);
    end
  end

  initial begin
    // idle state: internal-operation code, strobe inactive, no hold
    drive(4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 16'h0000, 16'h0000);
    // exhaustive sweep: every code against both directions and both strobe levels
    for (int c = 0; c < 16; c++) begin
      for (int rw = 0; rw < 2; rw++) begin
        for (int ds = 0; ds < 2; ds++) begin
          int idx;
          idx = c * 4 + rw * 2 + ds;
          drive(c[3:0], rw[0], ds[0], idx[0] ^ c[0], idx[1], idx[2],
                8'h5A ^ idx[7:0], 16'hC3A0 + idx[15:0],
                16'h1234 ^ (idx[15:0] * 16'h0101));
        end
      end
    end
    // acknowledge with all-ones address and all-zeros vector (R10 boundary)
    drive(4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'hFFFF, 16'h00A5);
    // acknowledge without data strobe: address passes, upper data forced (R9, R10)
    drive(4'h5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 16'h8001, 16'h0000);
    // non-vectored acknowledge is not reported (R8)
    drive(4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC3, 16'h4321, 16'hBEEF);
    @(posedge clk);
    wait (sb_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule